// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block decides, for each frame whose header fields have already been extracted by an upstream parser, whether the frame carries a precision time protocol event message. Eleven comparators test the destination addresses at layer 2, IPv4 and IPv6, the UDP destination port and the Ethertype against fixed protocol values. Two of the comparators instead use a configurable Ethertype and a configurable MAC destination. Fourteen rules each join two comparator hits. The frame is flagged when any rule that is left enabled fires and the frame's PTP version is allowed for its traffic direction.

Software programs two mask registers. One mask forces individual comparators to miss. The other switches off individual rules. Both masks come out of reset fully set, so the block reports nothing until software clears bits in them. A six-bit enable input holds the per-direction enable bit and the allowed versions. The result is a single registered pulse that a timestamp capture stage can use.

Top module: `ptp_frame_classifier`

## Requirements
- R1: `is_ptp_o` is registered. It can be high only in the cycle after a cycle with `hdr_valid_i` high, and it lasts one cycle for each strobe cycle.
- R2: After reset, both mask registers are all ones and `is_ptp_o` is 0. No frame is flagged until the masks are written.
- R3: When bit k of the comparator mask is 1, comparator k counts as a miss. The comparator indices are: 0 IPv4 dst 224.0.1.129; 1 IPv4 dst 224.0.0.107; 2 IPv6 dst FF0x::181; 3 IPv6 dst FF02::6B; 4 UDP port 319; 5 UDP port 320; 6 Ethertype 0x88F7; 7 configurable Ethertype; 8 MAC dst 01-1B-19-00-00-00; 9 MAC dst 01-80-C2-00-00-0E; 10 configurable MAC dst.
- R4: When bit r of the rule mask is 1, rule r can never fire.
- R5: Rules 0 to 3 pair comparator 0 or 1 with comparator 4 or 5, with the address index in bit 1 of r and the port in bit 0 of r. They fire only when `is_ipv4_i` is 1. Rules 4 to 7 pair comparator 2 or 3 with comparator 4 or 5 in the same way, and fire only when `is_ipv6_i` is 1.
- R6: Comparator 2 ignores bits [115:112] of the IPv6 destination and checks every other bit.
- R7: Rules 8 to 13 pair the MAC comparators with the Ethertype comparators in this order: (8,6), (9,6), (8,7), (9,7), (10,6), (10,7).
- R8: `enable_i[2:0]` controls the receive direction (`dir_tx_i`=0) and `enable_i[5:3]` controls transmit. In each group, bit 0 is the enable, bit 1 allows version 1 and bit 2 allows version 2. A frame is flagged only when its direction's enable bit is set together with at least one version bit.
- R9: A frame is flagged only if `ptp_ver_i` is 1 with the version-1 bit set, or 2 with the version-2 bit set. Any other version value is never flagged.
- R10: Every fixed comparator matches exactly its listed value. A neighbouring value misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header fields valid this cycle |
| dir_tx_i | input | 1 | 1 = transmit frame, 0 = receive frame |
| ethertype_i | input | 16 | Frame Ethertype |
| mac_da_i | input | 48 | MAC destination address |
| is_ipv4_i | input | 1 | Frame is IPv4 |
| ipv4_da_i | input | 32 | IPv4 destination address |
| is_ipv6_i | input | 1 | Frame is IPv6 |
| ipv6_da_i | input | 128 | IPv6 destination address |
| udp_dport_i | input | 16 | UDP destination port |
| ptp_ver_i | input | VER_W | PTP version field |
| enable_i | input | 6 | Per-direction enable and version bits |
| cfg_ethertype_i | input | 16 | Configurable Ethertype |
| cfg_mac_da_i | input | 48 | Configurable MAC destination |
| param_mask_we_i | input | 1 | Write strobe, comparator mask |
| param_mask_wdata_i | input | 11 | New comparator mask |
| rule_mask_we_i | input | 1 | Write strobe, rule mask |
| rule_mask_wdata_i | input | 14 | New rule mask |
| is_ptp_o | output | 1 | Frame classified as PTP event |

## Verification
The bench builds the block with the default four-bit version field. This lets it drive version codes 0, 3 and 15 as well as 1 and 2, so the version gate must reject values that lie outside the two legal codes and are not merely the other legal code. The bench also uses a configurable Ethertype and MAC destination that differ from every fixed value. Each of the configurable rules can therefore be told apart from the fixed rules that share one of its comparators.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  localparam int NUM_PARAMS = 11;
  localparam int NUM_RULES  = 14;
  localparam int EN_W       = 6;
  localparam int ET_W       = 16;
  localparam int MAC_W      = 48;
  localparam int V4_W       = 32;
  localparam int V6_W       = 128;
  localparam int PORT_W     = 16;

  localparam int IDX_V4_A   = 0;
  localparam int IDX_V4_B   = 1;
  localparam int IDX_V6_A   = 2;
  localparam int IDX_V6_B   = 3;
  localparam int IDX_UDP_EV = 4;
  localparam int IDX_UDP_GN = 5;
  localparam int IDX_ET_FIX = 6;
  localparam int IDX_ET_CFG = 7;
  localparam int IDX_DA_A   = 8;
  localparam int IDX_DA_B   = 9;
  localparam int IDX_DA_CFG = 10;

  localparam logic [V4_W-1:0]   V4_A_VAL  = 32'hE000_0181;
  localparam logic [V4_W-1:0]   V4_B_VAL  = 32'hE000_006B;
  localparam logic [11:0]       V6_A_TOP  = 12'hFF0;
  localparam logic [111:0]      V6_A_LOW  = 112'h181;
  localparam logic [V6_W-1:0]   V6_B_VAL  = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;
  localparam logic [PORT_W-1:0] UDP_EV    = 16'd319;
  localparam logic [PORT_W-1:0] UDP_GN    = 16'd320;
  localparam logic [ET_W-1:0]   ET_FIX    = 16'h88F7;
  localparam logic [MAC_W-1:0]  DA_A_VAL  = 48'h011B_1900_0000;
  localparam logic [MAC_W-1:0]  DA_B_VAL  = 48'h0180_C200_000E;

  typedef enum logic [1:0] {RK_L2, RK_V4, RK_V6} rule_kind_e;

  function automatic int rule_left(input int r);
    if (r < 4) return IDX_V4_A + r / 2;
    if (r < 8) return IDX_V6_A + (r - 4) / 2;
    if (r < 12) return IDX_DA_A + (r - 8) % 2;
    return IDX_DA_CFG;
  endfunction

  function automatic int rule_right(input int r);
    if (r < 8) return IDX_UDP_EV + r % 2;
    if (r < 12) return IDX_ET_FIX + (r - 8) / 2;
    return IDX_ET_FIX + (r - 12);
  endfunction

  function automatic rule_kind_e rule_kind(input int r);
    if (r < 4) return RK_V4;
    if (r < 8) return RK_V6;
    return RK_L2;
  endfunction
endpackage

// File: rtl/ptp_mask_regs.sv
module ptp_mask_regs
  import ptp_cls_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  param_we_i,
  input  logic [NUM_PARAMS-1:0] param_wdata_i,
  input  logic                  rule_we_i,
  input  logic [NUM_RULES-1:0]  rule_wdata_i,
  output logic [NUM_PARAMS-1:0] param_mask_o,
  output logic [NUM_RULES-1:0]  rule_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      param_mask_o <= '1;
      rule_mask_o  <= '1;
    end else begin
      if (param_we_i) param_mask_o <= param_wdata_i;
      if (rule_we_i)  rule_mask_o  <= rule_wdata_i;
    end
  end
endmodule

// File: rtl/ptp_field_match.sv
module ptp_field_match
  import ptp_cls_pkg::*;
(
  input  logic [ET_W-1:0]       ethertype_i,
  input  logic [MAC_W-1:0]      mac_da_i,
  input  logic [V4_W-1:0]       ipv4_da_i,
  input  logic [V6_W-1:0]       ipv6_da_i,
  input  logic [PORT_W-1:0]     udp_dport_i,
  input  logic [ET_W-1:0]       cfg_ethertype_i,
  input  logic [MAC_W-1:0]      cfg_mac_da_i,
  input  logic [NUM_PARAMS-1:0] param_mask_i,
  output logic [NUM_PARAMS-1:0] hit_o
);
  logic [NUM_PARAMS-1:0] raw;

  always_comb begin
    raw             = '0;
    raw[IDX_V4_A]   = (ipv4_da_i == V4_A_VAL);
    raw[IDX_V4_B]   = (ipv4_da_i == V4_B_VAL);
    // nibble [115:112] is the multicast scope: any value accepted
    raw[IDX_V6_A]   = (ipv6_da_i[127:116] == V6_A_TOP) && (ipv6_da_i[111:0] == V6_A_LOW);
    raw[IDX_V6_B]   = (ipv6_da_i == V6_B_VAL);
    raw[IDX_UDP_EV] = (udp_dport_i == UDP_EV);
    raw[IDX_UDP_GN] = (udp_dport_i == UDP_GN);
    raw[IDX_ET_FIX] = (ethertype_i == ET_FIX);
    raw[IDX_ET_CFG] = (ethertype_i == cfg_ethertype_i);
    raw[IDX_DA_A]   = (mac_da_i == DA_A_VAL);
    raw[IDX_DA_B]   = (mac_da_i == DA_B_VAL);
    raw[IDX_DA_CFG] = (mac_da_i == cfg_mac_da_i);
  end

  assign hit_o = raw & ~param_mask_i;
endmodule

// File: rtl/ptp_rule_eval.sv
module ptp_rule_eval
  import ptp_cls_pkg::*;
(
  input  logic [NUM_PARAMS-1:0] hit_i,
  input  logic                  is_ipv4_i,
  input  logic                  is_ipv6_i,
  input  logic [NUM_RULES-1:0]  rule_mask_i,
  output logic                  any_o
);
  logic [NUM_RULES-1:0] rule_hit;

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    localparam int         LA   = rule_left(r);
    localparam int         LB   = rule_right(r);
    localparam rule_kind_e KIND = rule_kind(r);
    logic qual;
    if (KIND == RK_V4) begin : g_v4
      assign qual = is_ipv4_i;
    end else if (KIND == RK_V6) begin : g_v6
      assign qual = is_ipv6_i;
    end else begin : g_l2
      assign qual = 1'b1;
    end
    assign rule_hit[r] = hit_i[LA] & hit_i[LB] & qual & ~rule_mask_i[r];
  end

  assign any_o = |rule_hit;
endmodule

// File: rtl/ptp_dir_gate.sv
module ptp_dir_gate
  import ptp_cls_pkg::*;
#(
  parameter int VER_W = 4
) (
  input  logic             dir_tx_i,
  input  logic [EN_W-1:0]  enable_i,
  input  logic [VER_W-1:0] ver_i,
  output logic             ok_o
);
  localparam int GRP_W = EN_W / 2;
  logic [GRP_W-1:0] grp;
  logic v1_ok, v2_ok;

  assign grp   = dir_tx_i ? enable_i[EN_W-1:GRP_W] : enable_i[GRP_W-1:0];
  assign v1_ok = grp[1] & (ver_i == VER_W'(1));
  assign v2_ok = grp[2] & (ver_i == VER_W'(2));
  assign ok_o  = grp[0] & (v1_ok | v2_ok);
endmodule

// File: rtl/ptp_frame_classifier.sv
module ptp_frame_classifier
  import ptp_cls_pkg::*;
#(
  parameter int VER_W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hdr_valid_i,
  input  logic                  dir_tx_i,
  input  logic [ET_W-1:0]       ethertype_i,
  input  logic [MAC_W-1:0]      mac_da_i,
  input  logic                  is_ipv4_i,
  input  logic [V4_W-1:0]       ipv4_da_i,
  input  logic                  is_ipv6_i,
  input  logic [V6_W-1:0]       ipv6_da_i,
  input  logic [PORT_W-1:0]     udp_dport_i,
  input  logic [VER_W-1:0]      ptp_ver_i,
  input  logic [EN_W-1:0]       enable_i,
  input  logic [ET_W-1:0]       cfg_ethertype_i,
  input  logic [MAC_W-1:0]      cfg_mac_da_i,
  input  logic                  param_mask_we_i,
  input  logic [NUM_PARAMS-1:0] param_mask_wdata_i,
  input  logic                  rule_mask_we_i,
  input  logic [NUM_RULES-1:0]  rule_mask_wdata_i,
  output logic                  is_ptp_o
);
  logic [NUM_PARAMS-1:0] param_mask_q;
  logic [NUM_RULES-1:0]  rule_mask_q;
  logic [NUM_PARAMS-1:0] hit;
  logic                  any_rule;
  logic                  dir_ok;

  ptp_mask_regs u_masks (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .param_we_i    (param_mask_we_i),
    .param_wdata_i (param_mask_wdata_i),
    .rule_we_i     (rule_mask_we_i),
    .rule_wdata_i  (rule_mask_wdata_i),
    .param_mask_o  (param_mask_q),
    .rule_mask_o   (rule_mask_q)
  );

  ptp_field_match u_match (
    .ethertype_i     (ethertype_i),
    .mac_da_i        (mac_da_i),
    .ipv4_da_i       (ipv4_da_i),
    .ipv6_da_i       (ipv6_da_i),
    .udp_dport_i     (udp_dport_i),
    .cfg_ethertype_i (cfg_ethertype_i),
    .cfg_mac_da_i    (cfg_mac_da_i),
    .param_mask_i    (param_mask_q),
    .hit_o           (hit)
  );

  ptp_rule_eval u_rules (
    .hit_i       (hit),
    .is_ipv4_i   (is_ipv4_i),
    .is_ipv6_i   (is_ipv6_i),
    .rule_mask_i (rule_mask_q),
    .any_o       (any_rule)
  );

  ptp_dir_gate #(.VER_W(VER_W)) u_gate (
    .dir_tx_i (dir_tx_i),
    .enable_i (enable_i),
    .ver_i    (ptp_ver_i),
    .ok_o     (dir_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) is_ptp_o <= 1'b0;
    else         is_ptp_o <= hdr_valid_i & any_rule & dir_ok;
  end
endmodule

// File: rtl/ptp_cls_chk.sv
module ptp_cls_chk
  import ptp_cls_pkg::*;
#(
  parameter int VER_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 hdr_valid_i,
  input logic                 dir_tx_i,
  input logic                 is_ipv4_i,
  input logic                 is_ipv6_i,
  input logic [VER_W-1:0]     ptp_ver_i,
  input logic [EN_W-1:0]      enable_i,
  input logic [NUM_RULES-1:0] rule_mask_q,
  input logic                 is_ptp_o
);
  p_pulse_after_strobe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ptp_o |-> $past(hdr_valid_i));

  p_masked_rules_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(&rule_mask_q) |-> !is_ptp_o);

  p_ip_qualifier_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!is_ipv4_i && !is_ipv6_i && (&rule_mask_q[NUM_RULES-1:8])) |-> !is_ptp_o);

  p_dir_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((!dir_tx_i && !enable_i[0]) || (dir_tx_i && !enable_i[3])) |-> !is_ptp_o);

  p_bad_version_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ptp_ver_i != VER_W'(1) && ptp_ver_i != VER_W'(2)) |-> !is_ptp_o);
endmodule

bind ptp_frame_classifier ptp_cls_chk #(.VER_W(VER_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_valid_i (hdr_valid_i),
  .dir_tx_i    (dir_tx_i),
  .is_ipv4_i   (is_ipv4_i),
  .is_ipv6_i   (is_ipv6_i),
  .ptp_ver_i   (ptp_ver_i),
  .enable_i    (enable_i),
  .rule_mask_q (rule_mask_q),
  .is_ptp_o    (is_ptp_o)
);

// File: tb/sim_ptp_frame_classifier.sv
module sim_ptp_frame_classifier;
  localparam int VER_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hdr_valid = 1'b0;
  logic dir_tx = 1'b0;
  logic [15:0] et = '0;
  logic [47:0] mac = '0;
  logic v4f = 1'b0, v6f = 1'b0;
  logic [31:0] v4 = '0;
  logic [127:0] v6 = '0;
  logic [15:0] port = '0;
  logic [VER_W-1:0] ver = '0;
  logic [5:0] en = '0;
  logic [15:0] cet = 16'h1234;
  logic [47:0] cmac = 48'h02AA_BBCC_DDEE;
  logic pm_we = 1'b0, rm_we = 1'b0;
  logic [10:0] pm_wd = '0;
  logic [13:0] rm_wd = '0;
  logic is_ptp;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  ptp_frame_classifier #(.VER_W(VER_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hdr_valid), .dir_tx_i(dir_tx),
    .ethertype_i(et), .mac_da_i(mac), .is_ipv4_i(v4f), .ipv4_da_i(v4),
    .is_ipv6_i(v6f), .ipv6_da_i(v6), .udp_dport_i(port), .ptp_ver_i(ver),
    .enable_i(en), .cfg_ethertype_i(cet), .cfg_mac_da_i(cmac),
    .param_mask_we_i(pm_we), .param_mask_wdata_i(pm_wd),
    .rule_mask_we_i(rm_we), .rule_mask_wdata_i(rm_wd), .is_ptp_o(is_ptp)
  );

  // reference model
  logic [10:0] m_pm;
  logic [13:0] m_rm;
  logic exp_q;
  int pa [14] = '{0, 0, 1, 1, 2, 2, 3, 3, 8, 9, 8, 9, 10, 10};
  int pb [14] = '{4, 5, 4, 5, 4, 5, 4, 5, 6, 6, 7, 7, 6, 7};

  function automatic bit ref_detect();
    bit p [11];
    bit any = 0;
    bit [2:0] g;
    p[0]  = (v4 == 32'hE000_0181);
    p[1]  = (v4 == 32'hE000_006B);
    p[2]  = (v6[127:116] == 12'hFF0) && (v6[111:0] == 112'h181);
    p[3]  = (v6 == 128'hFF02_0000_0000_0000_0000_0000_0000_006B);
    p[4]  = (port == 16'd319);
    p[5]  = (port == 16'd320);
    p[6]  = (et == 16'h88F7);
    p[7]  = (et == cet);
    p[8]  = (mac == 48'h011B_1900_0000);
    p[9]  = (mac == 48'h0180_C200_000E);
    p[10] = (mac == cmac);
    for (int k = 0; k < 11; k++) if (m_pm[k]) p[k] = 0;
    for (int r = 0; r < 14; r++) begin
      bit ok = p[pa[r]] && p[pb[r]] && !m_rm[r];
      if (r < 4 && !v4f) ok = 0;
      if (r >= 4 && r < 8 && !v6f) ok = 0;
      if (ok) any = 1;
    end
    g = dir_tx ? en[5:3] : en[2:0];
    return any && g[0] && ((g[1] && ver == 1) || (g[2] && ver == 2));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pm <= '1; m_rm <= '1; exp_q <= 1'b0;
    end else begin
      if (pm_we) m_pm <= pm_wd;
      if (rm_we) m_rm <= rm_wd;
      exp_q <= hdr_valid && ref_detect();
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (is_ptp !== exp_q) begin
        bad++;
        $display("FAIL %s model: is_ptp=%0b expected %0b", cur_req, is_ptp, exp_q);
      end
    end
  end

  task automatic check(input logic e, input string req);
    total++;
    if (is_ptp !== e) begin
      bad++;
      $display("FAIL %s: is_ptp=%0b expected %0b", req, is_ptp, e);
    end
  endtask

  task automatic frame(input logic e, input string req);
    cur_req = req;
    @(negedge clk) hdr_valid = 1'b1;
    @(negedge clk) hdr_valid = 1'b0;
    #1 check(e, req);
  endtask

  task automatic wr_masks(input logic [10:0] pm, input logic [13:0] rm);
    @(negedge clk) begin pm_we = 1; rm_we = 1; pm_wd = pm; rm_wd = rm; end
    @(negedge clk) begin pm_we = 0; rm_we = 0; end
  endtask

  task automatic clear_fields();
    et = 16'h0800; mac = 48'h0000_0000_0001; v4f = 0; v6f = 0;
    v4 = 32'h0A00_0001; v6 = 128'h1; port = 16'd53;
  endtask

  task automatic l2(input logic [15:0] t, input logic [47:0] d);
    clear_fields(); et = t; mac = d;
  endtask

  task automatic ip4(input logic [31:0] a, input logic [15:0] p, input logic f);
    clear_fields(); v4 = a; port = p; v4f = f;
  endtask

  task automatic ip6(input logic [127:0] a, input logic [15:0] p, input logic f);
    clear_fields(); v6 = a; port = p; v6f = f;
  endtask

  localparam logic [47:0] DA0 = 48'h011B_1900_0000;
  localparam logic [47:0] DA1 = 48'h0180_C200_000E;
  localparam logic [127:0] V6B = 128'hFF02_0000_0000_0000_0000_0000_0000_006B;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: is_ptp=%0b expected run end", is_ptp);
    finish_run();
  end

  initial begin
    clear_fields();
    en = 6'b111111; ver = 4'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check(1'b0, "R2");
    // R2: masks fully set after reset
    l2(16'h88F7, DA0); frame(1'b0, "R2");

    wr_masks('0, '0);
    // R7 pair order
    l2(16'h88F7, DA0); frame(1'b1, "R7");
    l2(16'h88F7, DA1); frame(1'b1, "R7");
    l2(cet, DA0);      frame(1'b1, "R7");
    l2(cet, cmac);     frame(1'b1, "R7");
    l2(16'h88F8, DA0); frame(1'b0, "R10");
    l2(16'h88F7, 48'h011B_1900_0001); frame(1'b0, "R10");

    // R1: output returns low the cycle after the pulse
    l2(16'h88F7, DA0); frame(1'b1, "R1");
    @(negedge clk) #1 check(1'b0, "R1");

    // R3: comparator 6 masked
    wr_masks(11'b000_0100_0000, '0);
    l2(16'h88F7, DA0); frame(1'b0, "R3");
    l2(cet, DA0);      frame(1'b1, "R3");

    // R4: rule 8 masked, rule 9 still live
    wr_masks('0, 14'b00_0001_0000_0000);
    l2(16'h88F7, DA0); frame(1'b0, "R4");
    l2(16'h88F7, DA1); frame(1'b1, "R4");
    // only rule 13 live: DA cfg with ET cfg
    wr_masks('0, 14'b01_1111_1111_1111);
    l2(cet, cmac);     frame(1'b1, "R7");
    l2(16'h88F7, cmac); frame(1'b0, "R7");

    wr_masks('0, '0);
    // R5: IP qualifiers
    ip4(32'hE000_0181, 16'd319, 1'b1); frame(1'b1, "R5");
    ip4(32'hE000_0181, 16'd319, 1'b0); frame(1'b0, "R5");
    ip4(32'hE000_0181, 16'd319, 1'b0); v6f = 1; frame(1'b0, "R5");
    ip6(V6B, 16'd320, 1'b1); frame(1'b1, "R5");
    ip6(V6B, 16'd320, 1'b0); frame(1'b0, "R5");
    // R10: fixed values
    ip4(32'hE000_006B, 16'd320, 1'b1); frame(1'b1, "R10");
    ip4(32'hE000_006B, 16'd321, 1'b1); frame(1'b0, "R10");
    ip4(32'hE000_0182, 16'd319, 1'b1); frame(1'b0, "R10");
    // R6: scope nibble wildcard
    ip6(128'hFF05_0000_0000_0000_0000_0000_0000_0181, 16'd319, 1'b1); frame(1'b1, "R6");
    ip6(128'hFF0E_0000_0000_0000_0000_0000_0000_0181, 16'd320, 1'b1); frame(1'b1, "R6");
    ip6(128'hFF15_0000_0000_0000_0000_0000_0000_0181, 16'd319, 1'b1); frame(1'b0, "R6");

    // R8: direction gating
    l2(16'h88F7, DA0);
    dir_tx = 1; en = 6'b000_111; frame(1'b0, "R8");
    en = 6'b111_000; frame(1'b1, "R8");
    en = 6'b001_000; frame(1'b0, "R8");
    dir_tx = 0; en = 6'b111_110; frame(1'b0, "R8");
    en = 6'b000_111; frame(1'b1, "R8");

    // R9: version values
    en = 6'b111_111;
    ver = 4'd1;  frame(1'b1, "R9");
    ver = 4'd3;  frame(1'b0, "R9");
    ver = 4'd0;  frame(1'b0, "R9");
    ver = 4'd15; frame(1'b0, "R9");
    en = 6'b000_011; ver = 4'd2; frame(1'b0, "R9");
    ver = 4'd1; frame(1'b1, "R9");

    // mixed traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (i % 50 == 0) begin
        pm_we = 1; rm_we = 1;
        pm_wd = 11'($urandom) & 11'($urandom);
        rm_wd = 14'($urandom) & 14'($urandom);
      end else begin
        pm_we = 0; rm_we = 0;
      end
      clear_fields();
      case ($urandom_range(0, 2))
        0: begin
          v4 = $urandom_range(0, 1) ? 32'hE000_0181 : 32'hE000_006B;
          v4f = 1'($urandom);
        end
        1: begin
          v6 = $urandom_range(0, 1) ? V6B :
               {12'hFF0, 4'($urandom), 112'h181};
          v6f = 1'($urandom);
        end
        default: begin
          mac = ($urandom_range(0, 2) == 0) ? DA0 : (1'($urandom) ? DA1 : cmac);
          et  = 1'($urandom) ? 16'h88F7 : cet;
        end
      endcase
      port = 1'($urandom) ? 16'd319 : 16'd320;
      dir_tx = 1'($urandom);
      en = 6'($urandom) | 6'b001_001;
      ver = VER_W'($urandom_range(0, 3));
      hdr_valid = 1'($urandom);
    end
    @(negedge clk) begin hdr_valid = 0; pm_we = 0; rm_we = 0; end
    repeat (2) @(negedge clk);
    #1 finish_run();
  end
endmodule